// File: doc/BRIEF.md
# Multi-Level I/O Translation Cache

This block is a fully associative cache of completed address translations for an I/O memory management unit. Each stored entry carries an address-space identifier, an input address aligned to the size of the block it maps, a translation granule code, the table level it was found at, the output address, the address mask of the block and two permission bits. The page-table walker fills the cache through an insert port; device traffic queries it through a lookup port; a command port removes entries when software changes the tables.

A lookup does not know in advance how large the mapping is. It starts at the first table level implied by the granule and region size and probes one level per clock, coarsest first, aligning the input address to that level's block size each time. The first level that matches ends the search. Hits and misses are counted. Invalidation can clear everything, everything of one address space, or a page range. A range invalidation removes both entries lying inside the range and block entries that contain the range start; when a single page with a known table level is named, an exact-key removal is tried before falling back to the range scan.

Top module: `iotlb_cache`

## Requirements
- R1: After reset no entry is valid, both counters read zero and `lk_busy`, `lk_done` and `lk_hit` are low.
- R2: An entry hits only when its ASID, aligned input address, granule code and level all equal the probe's; a difference in any one of them is a miss.
- R3: A lookup starts at level 4 - (inputsize - 4) / stride with inputsize = 64 - `lk_tsz` and stride = granule_log2 - 3, granule_log2 = 2 x code + 10 (code 1 = 4 KB, 2 = 16 KB, 3 = 64 KB). It probes one level per clock in increasing order up to level 3; `lk_done` pulses one cycle, n + 1 clocks after the request edge, when n levels were probed.
- R4: At each level the input address is cleared below bit granule_log2 + (3 - level) x (granule_log2 - 3) before comparing; the first hitting level returns that entry's output address, mask, permissions and level with `lk_hit` high.
- R5: Every completed lookup increments `hit_cnt` on a hit or `miss_cnt` on a miss, by exactly one.
- R6: An insert fills a free slot; an insert whose key equals a stored key replaces that entry, so a later lookup returns the newer data.
- R7: An insert into a cache with every slot valid first invalidates all entries, then writes the new one, leaving exactly one valid entry.
- R8: Command `cmd_op` = 1 invalidates every entry.
- R9: Command `cmd_op` = 2 invalidates every entry whose ASID equals `cmd_asid`; other entries stay.
- R10: Command `cmd_op` = 3 is a range invalidation with range granule 12 when `cmd_tg` = 0 and 2 x `cmd_tg` + 10 otherwise, and range mask (`cmd_npages` << granule) - 1. An entry is removed when (`cmd_iova` & ~entry mask) equals the entry address or (entry address & ~range mask) equals `cmd_iova`.
- R11: With `cmd_asid_any` high a range invalidation matches every ASID; with it low only entries whose ASID equals `cmd_asid` are removed.
- R12: When `cmd_ttl` is non-zero, `cmd_npages` is 1 and `cmd_asid_any` is low, a range command first removes only the entry whose key is {`cmd_asid`, `cmd_iova`, `cmd_tg`, `cmd_ttl`}; only if no such entry exists is the range scan of R10 applied.
- R13: `lk_busy` is high from the clock after an accepted request until the clock that raises `lk_done`; a request is accepted only while `lk_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Start a lookup |
| lk_asid | input | ASID_W | Lookup address-space ID |
| lk_iova | input | 64 | Lookup input address |
| lk_tg | input | 2 | Lookup granule code |
| lk_tsz | input | 6 | Region size field; inputsize = 64 - value |
| lk_busy | output | 1 | Lookup in progress |
| lk_done | output | 1 | One-cycle completion pulse |
| lk_hit | output | 1 | Completion was a hit |
| lk_pa | output | PA_W | Output address of the hit entry |
| lk_mask | output | 64 | Address mask of the hit entry |
| lk_perm | output | PERM_W | Permissions of the hit entry |
| lk_level | output | 2 | Level of the completed probe |
| ins_valid | input | 1 | Write a walk result |
| ins_asid | input | ASID_W | ASID of the new entry |
| ins_iova | input | 64 | Aligned input address of the new entry |
| ins_tg | input | 2 | Granule code of the new entry |
| ins_level | input | 2 | Level of the new entry |
| ins_pa | input | PA_W | Output address of the new entry |
| ins_mask | input | 64 | Address mask of the new entry |
| ins_perm | input | PERM_W | Permissions of the new entry |
| cmd_valid | input | 1 | Apply an invalidation command |
| cmd_op | input | 2 | 1 all, 2 by ASID, 3 range, 0 nothing |
| cmd_asid | input | ASID_W | ASID operand |
| cmd_asid_any | input | 1 | Range command ignores ASID |
| cmd_iova | input | 64 | Range start address |
| cmd_tg | input | 2 | Range granule code |
| cmd_npages | input | NPG_W | Number of pages in the range |
| cmd_ttl | input | 2 | Level hint, 0 when unknown |
| hit_cnt | output | CNT_W | Completed hits |
| miss_cnt | output | CNT_W | Completed misses |

## Verification
The assertions assume that a lookup is requested only while the block is idle, that an insert and a command never share a cycle, and that neither arrives while a probe is running, so the table a probe sees is fixed. They also assume inserted addresses are aligned to their masks and that lookups use a non-zero granule code with a region size giving a start level from 0 to 3. The stimulus keeps to this by issuing every operation from a task that waits for the previous one to finish, by drawing region sizes from a short list of legal values per granule, and by building each inserted mask from its level and granule.

// File: rtl/iotlb_pkg.sv
// Package: shared encodings and level arithmetic for the translation cache.
// Assumes granule code 1..3 for lookups and entries; code 0 only appears in
// range commands and is handled by the range calculator.
package iotlb_pkg;

    localparam int ADDR_W = 64;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_ALL   = 2'd1,
        OP_ASID  = 2'd2,
        OP_RANGE = 2'd3
    } inv_op_e;

    // Bit position below which a block at this level and granule is offset.
    function automatic logic [5:0] lvl_shift(input logic [1:0] lvl, input logic [1:0] code);
        int g;
        g = 2 * int'(code) + 10;
        return 6'(g + (3 - int'(lvl)) * (g - 3));
    endfunction

    // Mask of the offset bits inside one block.
    function automatic logic [ADDR_W-1:0] lvl_mask(input logic [1:0] lvl, input logic [1:0] code);
        return (ADDR_W'(1) << lvl_shift(lvl, code)) - ADDR_W'(1);
    endfunction

    // First table level implied by the granule and region size, clamped to 0..3.
    function automatic logic [1:0] start_level(input logic [1:0] code, input logic [5:0] tsz);
        int isz;
        int st;
        int lv;
        isz = 64 - int'(tsz);
        st  = 2 * int'(code) + 7;
        lv  = 4 - (isz - 4) / st;
        if (lv < 0) lv = 0;
        if (lv > 3) lv = 3;
        return 2'(lv);
    endfunction

endpackage

// File: rtl/iotlb_range_calc.sv
// Range calculator: turns a range command's granule code and page count into
// the range mask, and decides whether the exact-key removal is tried first.
// Purely combinational; assumes the caller only uses the result with OP_RANGE.
module iotlb_range_calc
    import iotlb_pkg::*;
#(
    parameter int NPG_W = 16
) (
    input  logic [1:0]        cmd_tg,
    input  logic [NPG_W-1:0]  cmd_npages,
    input  logic [1:0]        cmd_ttl,
    input  logic              cmd_asid_any,
    output logic [ADDR_W-1:0] rng_mask,
    output logic              try_exact
);

    logic [5:0] gran;

    // Range granule: 4 KB pages when no code is given.
    always_comb begin
        if (cmd_tg == 2'd0) gran = 6'd12;
        else                gran = 6'(2 * int'(cmd_tg) + 10);
        rng_mask  = (ADDR_W'(cmd_npages) << gran) - ADDR_W'(1);
        try_exact = (cmd_ttl != 2'd0) && (cmd_npages == NPG_W'(1)) && !cmd_asid_any;
    end

endmodule

// File: rtl/iotlb_store.sv
// Entry store: ENTRIES fully associative slots compared in parallel against
// the probe key, the insert key and the invalidation operands.
// Assumes an insert and a command never arrive in the same cycle.
module iotlb_store
    import iotlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ASID_W  = 16,
    parameter int PA_W    = 48,
    parameter int PERM_W  = 2,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [ASID_W-1:0] ins_asid,
    input  logic [ADDR_W-1:0] ins_iova,
    input  logic [1:0]        ins_tg,
    input  logic [1:0]        ins_level,
    input  logic [PA_W-1:0]   ins_pa,
    input  logic [ADDR_W-1:0] ins_mask,
    input  logic [PERM_W-1:0] ins_perm,
    input  logic              cmd_valid,
    input  inv_op_e           cmd_op,
    input  logic [ASID_W-1:0] cmd_asid,
    input  logic              cmd_asid_any,
    input  logic [ADDR_W-1:0] cmd_iova,
    input  logic [1:0]        cmd_tg,
    input  logic [1:0]        cmd_ttl,
    input  logic [ADDR_W-1:0] rng_mask,
    input  logic              try_exact,
    input  logic [ASID_W-1:0] pk_asid,
    input  logic [ADDR_W-1:0] pk_iova,
    input  logic [1:0]        pk_tg,
    input  logic [1:0]        pk_level,
    output logic              pk_hit,
    output logic [PA_W-1:0]   pk_pa,
    output logic [ADDR_W-1:0] pk_mask,
    output logic [PERM_W-1:0] pk_perm
);

    logic [ENTRIES-1:0] valid_q;
    logic [ASID_W-1:0]  asid_q [ENTRIES];
    logic [ADDR_W-1:0]  iova_q [ENTRIES];
    logic [1:0]         tg_q   [ENTRIES];
    logic [1:0]         lvl_q  [ENTRIES];
    logic [PA_W-1:0]    pa_q   [ENTRIES];
    logic [ADDR_W-1:0]  mask_q [ENTRIES];
    logic [PERM_W-1:0]  perm_q [ENTRIES];

    logic [ENTRIES-1:0] probe_hit;
    logic [ENTRIES-1:0] dup_hit;
    logic [ENTRIES-1:0] exact_hit;
    logic [ENTRIES-1:0] range_hit;
    logic [ENTRIES-1:0] asid_hit;
    logic               full;
    logic               use_exact;
    logic [IDX_W-1:0]   wr_idx;

    genvar gi;
    for (gi = 0; gi < ENTRIES; gi++) begin : g_ent
        logic asid_eq;
        logic inside_rng;
        logic holds_start;

        // Per-slot comparators for every port that looks at the slot.
        always_comb begin
            asid_eq       = (asid_q[gi] == cmd_asid);
            probe_hit[gi] = valid_q[gi] && (asid_q[gi] == pk_asid) && (iova_q[gi] == pk_iova)
                            && (tg_q[gi] == pk_tg) && (lvl_q[gi] == pk_level);
            dup_hit[gi]   = valid_q[gi] && (asid_q[gi] == ins_asid) && (iova_q[gi] == ins_iova)
                            && (tg_q[gi] == ins_tg) && (lvl_q[gi] == ins_level);
            exact_hit[gi] = valid_q[gi] && asid_eq && (iova_q[gi] == cmd_iova)
                            && (tg_q[gi] == cmd_tg) && (lvl_q[gi] == cmd_ttl);
            asid_hit[gi]  = valid_q[gi] && asid_eq;
            holds_start   = ((cmd_iova & ~mask_q[gi]) == iova_q[gi]);
            inside_rng    = ((iova_q[gi] & ~rng_mask) == cmd_iova);
            range_hit[gi] = valid_q[gi] && (cmd_asid_any || asid_eq) && (holds_start || inside_rng);
        end

        AST_ASID_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op == OP_ASID && valid_q[gi] && asid_q[gi] == cmd_asid)
            |=> !valid_q[gi]); // R9
    end

    assign full      = &valid_q;
    assign use_exact = try_exact && (|exact_hit);

    // Slot choice for an insert: same key first, else lowest free, slot 0 when full.
    always_comb begin
        logic found;
        found  = 1'b0;
        wr_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && !valid_q[i]) begin
                wr_idx = IDX_W'(i);
                found  = 1'b1;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (dup_hit[i]) wr_idx = IDX_W'(i);
        end
        if (full) wr_idx = '0;
    end

    // Probe result: OR of the (at most one) hitting slot's fields.
    always_comb begin
        pk_hit  = |probe_hit;
        pk_pa   = '0;
        pk_mask = '0;
        pk_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (probe_hit[i]) begin
                pk_pa   = pk_pa   | pa_q[i];
                pk_mask = pk_mask | mask_q[i];
                pk_perm = pk_perm | perm_q[i];
            end
        end
    end

    // Valid bits: invalidation commands, then inserts with flush-on-full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (cmd_valid) begin
            case (cmd_op)
                OP_ALL:   valid_q <= '0;
                OP_ASID:  valid_q <= valid_q & ~asid_hit;
                OP_RANGE: valid_q <= valid_q & ~(use_exact ? exact_hit : range_hit);
                default:  valid_q <= valid_q;
            endcase
        end else if (ins_valid) begin
            if (full) valid_q <= ENTRIES'(1);
            else      valid_q[wr_idx] <= 1'b1;
        end
    end

    // Entry payload: written on insert only; contents of invalid slots are don't-care.
    always_ff @(posedge clk) begin
        if (ins_valid && !cmd_valid) begin
            asid_q[wr_idx] <= ins_asid;
            iova_q[wr_idx] <= ins_iova;
            tg_q[wr_idx]   <= ins_tg;
            lvl_q[wr_idx]  <= ins_level;
            pa_q[wr_idx]   <= ins_pa;
            mask_q[wr_idx] <= ins_mask;
            perm_q[wr_idx] <= ins_perm;
        end
    end

    AST_NO_CMD_INS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && ins_valid)); // R7
    AST_FULL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !cmd_valid && full) |=> ($countones(valid_q) == 1)); // R7
    AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ALL) |=> (valid_q == '0)); // R8
    AST_UNIQUE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(probe_hit)); // R6

endmodule

// File: rtl/iotlb_probe.sv
// Lookup sequencer: latches a request, walks the levels from the start level
// to level 3 one per clock, reports the first hit or a miss, counts both.
// Assumes requests only while idle and a stable store during a probe.
module iotlb_probe
    import iotlb_pkg::*;
#(
    parameter int ASID_W = 16,
    parameter int PA_W   = 48,
    parameter int PERM_W = 2,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [ADDR_W-1:0] lk_iova,
    input  logic [1:0]        lk_tg,
    input  logic [5:0]        lk_tsz,
    output logic [ASID_W-1:0] pk_asid,
    output logic [ADDR_W-1:0] pk_iova,
    output logic [1:0]        pk_tg,
    output logic [1:0]        pk_level,
    input  logic              pk_hit,
    input  logic [PA_W-1:0]   pk_pa,
    input  logic [ADDR_W-1:0] pk_mask,
    input  logic [PERM_W-1:0] pk_perm,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic [PA_W-1:0]   res_pa,
    output logic [ADDR_W-1:0] res_mask,
    output logic [PERM_W-1:0] res_perm,
    output logic [1:0]        res_level,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [CNT_W-1:0]  miss_cnt
);

    logic              busy_q;
    logic [1:0]        lvl_q;
    logic [ASID_W-1:0] asid_q;
    logic [ADDR_W-1:0] iova_q;
    logic [1:0]        tg_q;

    assign busy     = busy_q;
    assign pk_asid  = asid_q;
    assign pk_tg    = tg_q;
    assign pk_level = lvl_q;
    assign pk_iova  = iova_q & ~lvl_mask(lvl_q, tg_q);

    // Sequencer: accept, step one level per clock, finish on hit or after level 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            lvl_q     <= '0;
            asid_q    <= '0;
            iova_q    <= '0;
            tg_q      <= '0;
            done      <= 1'b0;
            hit       <= 1'b0;
            res_pa    <= '0;
            res_mask  <= '0;
            res_perm  <= '0;
            res_level <= '0;
            hit_cnt   <= '0;
            miss_cnt  <= '0;
        end else begin
            done <= 1'b0;
            hit  <= 1'b0;
            if (!busy_q) begin
                if (lk_req) begin
                    busy_q <= 1'b1;
                    lvl_q  <= start_level(lk_tg, lk_tsz);
                    asid_q <= lk_asid;
                    iova_q <= lk_iova;
                    tg_q   <= lk_tg;
                end
            end else if (pk_hit) begin
                busy_q    <= 1'b0;
                done      <= 1'b1;
                hit       <= 1'b1;
                res_pa    <= pk_pa;
                res_mask  <= pk_mask;
                res_perm  <= pk_perm;
                res_level <= lvl_q;
                hit_cnt   <= hit_cnt + CNT_W'(1);
            end else if (lvl_q == 2'd3) begin
                busy_q    <= 1'b0;
                done      <= 1'b1;
                res_pa    <= '0;
                res_mask  <= '0;
                res_perm  <= '0;
                res_level <= lvl_q;
                miss_cnt  <= miss_cnt + CNT_W'(1);
            end else begin
                lvl_q <= lvl_q + 2'd1;
            end
        end
    end

    AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> !busy_q); // R13
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !pk_hit && lvl_q != 2'd3) |=> (busy_q && lvl_q == $past(lvl_q) + 2'd1)); // R3
    AST_HIT_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> done); // R4
    AST_HIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hit) |-> (hit_cnt == $past(hit_cnt) + CNT_W'(1) && $stable(miss_cnt))); // R5
    AST_MISS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (miss_cnt == $past(miss_cnt) + CNT_W'(1) && $stable(hit_cnt))); // R5

endmodule

// File: rtl/iotlb_cache.sv
// Top: multi-level translation cache. Wires the lookup sequencer, the entry
// store and the range calculator together. Assumes the input contract in the
// brief: idle-only requests, no insert or command during a probe or together.
module iotlb_cache
    import iotlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ASID_W  = 16,
    parameter int PA_W    = 48,
    parameter int PERM_W  = 2,
    parameter int NPG_W   = 16,
    parameter int CNT_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [63:0]       lk_iova,
    input  logic [1:0]        lk_tg,
    input  logic [5:0]        lk_tsz,
    output logic              lk_busy,
    output logic              lk_done,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic [63:0]       lk_mask,
    output logic [PERM_W-1:0] lk_perm,
    output logic [1:0]        lk_level,
    input  logic              ins_valid,
    input  logic [ASID_W-1:0] ins_asid,
    input  logic [63:0]       ins_iova,
    input  logic [1:0]        ins_tg,
    input  logic [1:0]        ins_level,
    input  logic [PA_W-1:0]   ins_pa,
    input  logic [63:0]       ins_mask,
    input  logic [PERM_W-1:0] ins_perm,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ASID_W-1:0] cmd_asid,
    input  logic              cmd_asid_any,
    input  logic [63:0]       cmd_iova,
    input  logic [1:0]        cmd_tg,
    input  logic [NPG_W-1:0]  cmd_npages,
    input  logic [1:0]        cmd_ttl,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [CNT_W-1:0]  miss_cnt
);

    logic [ASID_W-1:0] pk_asid;
    logic [ADDR_W-1:0] pk_iova;
    logic [1:0]        pk_tg;
    logic [1:0]        pk_level;
    logic              pk_hit;
    logic [PA_W-1:0]   pk_pa;
    logic [ADDR_W-1:0] pk_mask;
    logic [PERM_W-1:0] pk_perm;
    logic [ADDR_W-1:0] rng_mask;
    logic              try_exact;
    inv_op_e           op;

    assign op = inv_op_e'(cmd_op);

    iotlb_range_calc #(.NPG_W(NPG_W)) u_rng (
        .cmd_tg       (cmd_tg),
        .cmd_npages   (cmd_npages),
        .cmd_ttl      (cmd_ttl),
        .cmd_asid_any (cmd_asid_any),
        .rng_mask     (rng_mask),
        .try_exact    (try_exact)
    );

    iotlb_store #(
        .ENTRIES (ENTRIES),
        .ASID_W  (ASID_W),
        .PA_W    (PA_W),
        .PERM_W  (PERM_W)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .ins_valid    (ins_valid),
        .ins_asid     (ins_asid),
        .ins_iova     (ins_iova),
        .ins_tg       (ins_tg),
        .ins_level    (ins_level),
        .ins_pa       (ins_pa),
        .ins_mask     (ins_mask),
        .ins_perm     (ins_perm),
        .cmd_valid    (cmd_valid),
        .cmd_op       (op),
        .cmd_asid     (cmd_asid),
        .cmd_asid_any (cmd_asid_any),
        .cmd_iova     (cmd_iova),
        .cmd_tg       (cmd_tg),
        .cmd_ttl      (cmd_ttl),
        .rng_mask     (rng_mask),
        .try_exact    (try_exact),
        .pk_asid      (pk_asid),
        .pk_iova      (pk_iova),
        .pk_tg        (pk_tg),
        .pk_level     (pk_level),
        .pk_hit       (pk_hit),
        .pk_pa        (pk_pa),
        .pk_mask      (pk_mask),
        .pk_perm      (pk_perm)
    );

    iotlb_probe #(
        .ASID_W (ASID_W),
        .PA_W   (PA_W),
        .PERM_W (PERM_W),
        .CNT_W  (CNT_W)
    ) u_probe (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_req    (lk_req),
        .lk_asid   (lk_asid),
        .lk_iova   (lk_iova),
        .lk_tg     (lk_tg),
        .lk_tsz    (lk_tsz),
        .pk_asid   (pk_asid),
        .pk_iova   (pk_iova),
        .pk_tg     (pk_tg),
        .pk_level  (pk_level),
        .pk_hit    (pk_hit),
        .pk_pa     (pk_pa),
        .pk_mask   (pk_mask),
        .pk_perm   (pk_perm),
        .busy      (lk_busy),
        .done      (lk_done),
        .hit       (lk_hit),
        .res_pa    (lk_pa),
        .res_mask  (lk_mask),
        .res_perm  (lk_perm),
        .res_level (lk_level),
        .hit_cnt   (hit_cnt),
        .miss_cnt  (miss_cnt)
    );

    AST_QUIET_DURING_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_busy |-> !(ins_valid || cmd_valid)); // R13

endmodule

// File: tb/iotlb_cache_tb.sv
module iotlb_cache_tb;

    localparam int ENT = 8;
    localparam int AW  = 16;
    localparam int PW  = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_req = 1'b0;
    logic [AW-1:0] lk_asid = '0;
    logic [63:0]   lk_iova = '0;
    logic [1:0]    lk_tg = 2'd1;
    logic [5:0]    lk_tsz = 6'd16;
    logic          lk_busy, lk_done, lk_hit;
    logic [PW-1:0] lk_pa;
    logic [63:0]   lk_mask;
    logic [1:0]    lk_perm, lk_level;
    logic          ins_valid = 1'b0;
    logic [AW-1:0] ins_asid = '0;
    logic [63:0]   ins_iova = '0;
    logic [1:0]    ins_tg = '0, ins_level = '0, ins_perm = '0;
    logic [PW-1:0] ins_pa = '0;
    logic [63:0]   ins_mask = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [AW-1:0] cmd_asid = '0;
    logic          cmd_asid_any = 1'b0;
    logic [63:0]   cmd_iova = '0;
    logic [1:0]    cmd_tg = '0;
    logic [15:0]   cmd_npages = '0;
    logic [1:0]    cmd_ttl = '0;
    logic [31:0]   hit_cnt, miss_cnt;

    iotlb_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_asid(lk_asid), .lk_iova(lk_iova), .lk_tg(lk_tg), .lk_tsz(lk_tsz),
        .lk_busy(lk_busy), .lk_done(lk_done), .lk_hit(lk_hit), .lk_pa(lk_pa),
        .lk_mask(lk_mask), .lk_perm(lk_perm), .lk_level(lk_level),
        .ins_valid(ins_valid), .ins_asid(ins_asid), .ins_iova(ins_iova), .ins_tg(ins_tg),
        .ins_level(ins_level), .ins_pa(ins_pa), .ins_mask(ins_mask), .ins_perm(ins_perm),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_asid(cmd_asid), .cmd_asid_any(cmd_asid_any),
        .cmd_iova(cmd_iova), .cmd_tg(cmd_tg), .cmd_npages(cmd_npages), .cmd_ttl(cmd_ttl),
        .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model
    bit          m_v    [ENT];
    logic [AW-1:0] m_asid [ENT];
    logic [63:0] m_iova [ENT];
    logic [1:0]  m_tg   [ENT];
    logic [1:0]  m_lvl  [ENT];
    logic [PW-1:0] m_pa [ENT];
    logic [63:0] m_mask [ENT];
    logic [1:0]  m_perm [ENT];
    int m_hits = 0;
    int m_miss = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] b_mask(input logic [1:0] lvl, input logic [1:0] tg);
        int g;
        int sh;
        g  = 2 * int'(tg) + 10;
        sh = g + (3 - int'(lvl)) * (g - 3);
        return (64'd1 << sh) - 64'd1;
    endfunction

    function automatic int b_start(input logic [1:0] tg, input logic [5:0] tsz);
        int lv;
        lv = 4 - ((64 - int'(tsz)) - 4) / (2 * int'(tg) + 7);
        if (lv < 0) lv = 0;
        if (lv > 3) lv = 3;
        return lv;
    endfunction

    function automatic logic [5:0] pick_tsz(input logic [1:0] tg, input bit alt);
        case (tg)
            2'd1:    return alt ? 6'd25 : 6'd16;
            2'd2:    return alt ? 6'd28 : 6'd17;
            default: return alt ? 6'd10 : 6'd22;
        endcase
    endfunction

    task automatic m_insert(input logic [AW-1:0] a, input logic [63:0] va, input logic [1:0] tg,
                            input logic [1:0] lv, input logic [PW-1:0] pa, input logic [1:0] pm);
        int slot = -1;
        int cnt = 0;
        for (int i = 0; i < ENT; i++) if (m_v[i]) cnt++;
        if (cnt == ENT) begin
            for (int i = 0; i < ENT; i++) m_v[i] = 1'b0;
            slot = 0;
        end else begin
            for (int i = 0; i < ENT; i++)
                if (m_v[i] && m_asid[i] == a && m_iova[i] == va && m_tg[i] == tg && m_lvl[i] == lv) slot = i;
            for (int i = 0; i < ENT; i++) if (slot < 0 && !m_v[i]) slot = i;
        end
        m_v[slot] = 1'b1; m_asid[slot] = a; m_iova[slot] = va; m_tg[slot] = tg;
        m_lvl[slot] = lv; m_pa[slot] = pa; m_mask[slot] = b_mask(lv, tg); m_perm[slot] = pm;
    endtask

    task automatic m_command(input logic [1:0] op, input logic [AW-1:0] a, input bit any,
                             input logic [63:0] va, input logic [1:0] tg, input logic [15:0] np,
                             input logic [1:0] ttl);
        if (op == 2'd1) begin
            for (int i = 0; i < ENT; i++) m_v[i] = 1'b0;
        end else if (op == 2'd2) begin
            for (int i = 0; i < ENT; i++) if (m_asid[i] == a) m_v[i] = 1'b0;
        end else if (op == 2'd3) begin
            bit removed = 1'b0;
            if (ttl != 0 && np == 16'd1 && !any) begin
                for (int i = 0; i < ENT; i++)
                    if (m_v[i] && m_asid[i] == a && m_iova[i] == va && m_tg[i] == tg && m_lvl[i] == ttl) begin
                        m_v[i] = 1'b0; removed = 1'b1;
                    end
            end
            if (!removed) begin
                int g;
                logic [63:0] rm;
                g  = (tg == 0) ? 12 : 2 * int'(tg) + 10;
                rm = ({48'd0, np} << g) - 64'd1;
                for (int i = 0; i < ENT; i++)
                    if (m_v[i] && (any || m_asid[i] == a) &&
                        (((va & ~m_mask[i]) == m_iova[i]) || ((m_iova[i] & ~rm) == va))) m_v[i] = 1'b0;
            end
        end
    endtask

    task automatic do_insert(input logic [AW-1:0] a, input logic [63:0] va, input logic [1:0] tg,
                             input logic [1:0] lv, input logic [PW-1:0] pa, input logic [1:0] pm);
        @(negedge clk);
        ins_valid = 1'b1; ins_asid = a; ins_iova = va; ins_tg = tg; ins_level = lv;
        ins_pa = pa; ins_mask = b_mask(lv, tg); ins_perm = pm;
        @(negedge clk);
        ins_valid = 1'b0;
        m_insert(a, va, tg, lv, pa, pm);
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [AW-1:0] a, input bit any,
                          input logic [63:0] va, input logic [1:0] tg, input logic [15:0] np,
                          input logic [1:0] ttl);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_asid = a; cmd_asid_any = any;
        cmd_iova = va; cmd_tg = tg; cmd_npages = np; cmd_ttl = ttl;
        @(negedge clk);
        cmd_valid = 1'b0;
        m_command(op, a, any, va, tg, np, ttl);
    endtask

    // Lookup with full comparison against the model; req names the requirement checked.
    task automatic do_lookup(input logic [AW-1:0] a, input logic [63:0] va, input logic [1:0] tg,
                             input logic [5:0] tsz, input string req);
        int st;
        int tries;
        int n = 0;
        bit e_hit = 1'b0;
        int slot = -1;
        int hl = 3;
        st = b_start(tg, tsz);
        for (int l = st; l <= 3 && !e_hit; l++) begin
            for (int i = 0; i < ENT; i++)
                if (m_v[i] && m_asid[i] == a && m_tg[i] == tg && m_lvl[i] == 2'(l) &&
                    m_iova[i] == (va & ~b_mask(2'(l), tg))) begin
                    e_hit = 1'b1; slot = i; hl = l;
                end
        end
        tries = hl - st + 1;
        @(negedge clk);
        lk_req = 1'b1; lk_asid = a; lk_iova = va; lk_tg = tg; lk_tsz = tsz;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            lk_req = 1'b0;
        end while (!lk_done && n < 12);
        chk(req, "hit", 64'(lk_hit), 64'(e_hit));
        chk("R3", "cycles", 64'(n), 64'(tries + 1));
        if (e_hit) begin
            m_hits++;
            chk("R4", "pa", 64'(lk_pa), 64'(m_pa[slot]));
            chk("R4", "mask", lk_mask, m_mask[slot]);
            chk("R4", "perm", 64'(lk_perm), 64'(m_perm[slot]));
            chk("R4", "level", 64'(lk_level), 64'(hl));
        end else begin
            m_miss++;
        end
        @(negedge clk);
        chk("R13", "busy_after", 64'(lk_busy), 64'd0);
    endtask

    function automatic logic [63:0] rnd48();
        return {16'd0, 16'($urandom), 32'($urandom)};
    endfunction

    initial begin
        #(200000 * 10);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL R3 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < ENT; i++) m_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "hit_cnt", 64'(hit_cnt), 64'd0);
        chk("R1", "miss_cnt", 64'(miss_cnt), 64'd0);
        chk("R1", "busy", 64'(lk_busy), 64'd0);
        chk("R1", "done", 64'(lk_done), 64'd0);
        chk("R1", "hit", 64'(lk_hit), 64'd0);
        do_lookup(16'd1, 64'h0000_8000_3000, 2'd1, 6'd16, "R1");

        // R2/R4 page entry and one-field mismatches
        do_insert(16'd1, 64'h0000_8000_3000, 2'd1, 2'd3, 48'h0000_1234_5000, 2'd3);
        do_lookup(16'd1, 64'h0000_8000_3abc, 2'd1, 6'd16, "R2");
        do_lookup(16'd2, 64'h0000_8000_3abc, 2'd1, 6'd16, "R2");
        do_lookup(16'd1, 64'h0000_8000_4000, 2'd1, 6'd16, "R2");
        do_lookup(16'd1, 64'h0000_8000_3000, 2'd2, 6'd17, "R2");
        // R3 start level variants, block entry hit at level 1
        do_insert(16'd1, 64'h0000_4000_0000, 2'd1, 2'd1, 48'h0000_c000_0000, 2'd1);
        do_lookup(16'd1, 64'h0000_4123_4567, 2'd1, 6'd16, "R3");
        do_lookup(16'd1, 64'h0000_4123_4567, 2'd1, 6'd25, "R3");
        // R6 same-key replacement
        do_insert(16'd1, 64'h0000_8000_3000, 2'd1, 2'd3, 48'h0000_0abc_d000, 2'd2);
        do_lookup(16'd1, 64'h0000_8000_3010, 2'd1, 6'd16, "R6");

        // R10 range: containing block and entries inside range
        do_insert(16'd1, 64'h0000_8000_9000, 2'd1, 2'd3, 48'h0000_0000_9000, 2'd3);
        do_cmd(2'd3, 16'd1, 1'b0, 64'h0000_4000_2000, 2'd1, 16'd1, 2'd0);
        do_lookup(16'd1, 64'h0000_4000_2000, 2'd1, 6'd16, "R10");
        do_cmd(2'd3, 16'd1, 1'b0, 64'h0000_8000_0000, 2'd1, 16'd8, 2'd0);
        do_lookup(16'd1, 64'h0000_8000_3000, 2'd1, 6'd16, "R10");
        do_lookup(16'd1, 64'h0000_8000_9000, 2'd1, 6'd16, "R10");
        // R11 ASID filter, then wildcard with code 0 (4 KB granule)
        do_insert(16'd2, 64'h0000_9000_2000, 2'd1, 2'd3, 48'h0000_0002_0000, 2'd1);
        do_cmd(2'd3, 16'd3, 1'b0, 64'h0000_9000_0000, 2'd0, 16'd4, 2'd0);
        do_lookup(16'd2, 64'h0000_9000_2000, 2'd1, 6'd16, "R11");
        do_cmd(2'd3, 16'd5, 1'b1, 64'h0000_9000_0000, 2'd0, 16'd4, 2'd0);
        do_lookup(16'd2, 64'h0000_9000_2000, 2'd1, 6'd16, "R11");
        // R12 exact-key removal spares the containing block; fallback removes it
        do_insert(16'd1, 64'h0000_4000_0000, 2'd1, 2'd1, 48'h0000_c000_0000, 2'd1);
        do_insert(16'd1, 64'h0000_4000_5000, 2'd1, 2'd3, 48'h0000_0005_5000, 2'd3);
        do_cmd(2'd3, 16'd1, 1'b0, 64'h0000_4000_5000, 2'd1, 16'd1, 2'd3);
        do_lookup(16'd1, 64'h0000_4000_5000, 2'd1, 6'd16, "R12");
        do_cmd(2'd3, 16'd1, 1'b0, 64'h0000_4000_5000, 2'd1, 16'd1, 2'd2);
        do_lookup(16'd1, 64'h0000_4000_5000, 2'd1, 6'd16, "R12");
        // R9 invalidate by ASID
        do_insert(16'd1, 64'h0000_0010_0000, 2'd1, 2'd3, 48'h1, 2'd1);
        do_insert(16'd2, 64'h0000_0010_0000, 2'd1, 2'd3, 48'h2, 2'd1);
        do_cmd(2'd2, 16'd1, 1'b0, 64'h0, 2'd0, 16'd0, 2'd0);
        do_lookup(16'd1, 64'h0000_0010_0000, 2'd1, 6'd16, "R9");
        do_lookup(16'd2, 64'h0000_0010_0000, 2'd1, 6'd16, "R9");
        // R8 invalidate all
        do_cmd(2'd1, 16'd0, 1'b0, 64'h0, 2'd0, 16'd0, 2'd0);
        do_lookup(16'd2, 64'h0000_0010_0000, 2'd1, 6'd16, "R8");
        // R7 full cache flush on insert
        for (int i = 0; i < ENT + 1; i++)
            do_insert(16'd4, 64'h0000_0100_0000 + 64'(i) * 64'h1000, 2'd1, 2'd3, 48'(i + 16), 2'd2);
        do_lookup(16'd4, 64'h0000_0100_0000, 2'd1, 6'd16, "R7");
        do_lookup(16'd4, 64'h0000_0100_7000, 2'd1, 6'd16, "R7");
        do_lookup(16'd4, 64'h0000_0100_8000, 2'd1, 6'd16, "R7");

        // mixed random traffic against the model
        for (int it = 0; it < 700; it++) begin
            int r = $urandom % 10;
            logic [1:0] tg = 2'(1 + $urandom % 3);
            logic [1:0] lv = 2'(1 + $urandom % 3);
            logic [AW-1:0] a = AW'(1 + $urandom % 3);
            if (r < 4) begin
                do_insert(a, rnd48() & ~b_mask(lv, tg), tg, lv, 48'(rnd48()), 2'($urandom));
            end else if (r < 8) begin
                int s = $urandom % ENT;
                if (m_v[s] && ($urandom % 4 != 0))
                    do_lookup(m_asid[s], m_iova[s] | (rnd48() & m_mask[s]), m_tg[s],
                              pick_tsz(m_tg[s], 1'($urandom)), "R2");
                else
                    do_lookup(a, rnd48(), tg, pick_tsz(tg, 1'($urandom)), "R2");
            end else if (r == 8) begin
                int s = $urandom % ENT;
                logic [15:0] np = 16'(1 + $urandom % 4);
                logic [1:0] ctg = 2'($urandom);
                logic [63:0] va = m_iova[s] & ~((64'(np) << ((ctg == 0) ? 12 : 2 * int'(ctg) + 10)) - 1);
                if ($urandom % 2 == 0) va = m_iova[s];
                do_cmd(2'd3, m_asid[s], 1'($urandom % 4 == 0), va, ctg, np, 2'($urandom));
            end else begin
                if ($urandom % 6 == 0) do_cmd(2'd1, a, 1'b0, 64'h0, 2'd0, 16'd0, 2'd0);
                else                   do_cmd(2'd2, a, 1'b0, 64'h0, 2'd0, 16'd0, 2'd0);
            end
        end

        // R5 counters against the model's tally
        chk("R5", "hit_cnt", 64'(hit_cnt), 64'(m_hits));
        chk("R5", "miss_cnt", 64'(miss_cnt), 64'(m_miss));
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule